// File: doc/BRIEF.md
# SPI Serial Static Memory Slave

This block is a synthesizable model of a byte-wide static memory that a host reaches over a four-wire SPI link with an extra active-low pause input. The host lowers chip select and shifts in an 8-bit instruction. Memory instructions carry a 16-bit address next, and the data bytes follow. Every field travels most significant bit first. The slave answers on a serial output that is driven only while it has something to send. An enable pin beside it tells the pad or the bus model when to drive.

The block runs on a fast system clock. It oversamples the serial pins through synchronizer flops and acts on the SCK edges it detects, so the whole design lives in one clock domain and the array maps onto block RAM. An internal mode byte chooses how the address pointer moves after each byte:
- single-byte transfers,
- looping inside an aligned page,
- streaming through the whole array with wrap at the top.

The full-size part uses `ADDR_W = 13` (8192 bytes). SCK high and low phases must each last at least three system clocks.

Top module: `spi_sram`

## Requirements
- R1: After synchronous reset, `so_oe` is low and the mode byte reads back as 0x00 (single-byte mode).
- R2: A transaction starts when `cs_n` falls. SI is sampled on rising SCK. The 8-bit instruction comes first, then a 16-bit address, both MSB first. Address bits at and above `ADDR_W` are ignored, so 0xE034 reaches the same byte as 0x0034 when `ADDR_W = 8`.
- R3: Instruction 0x02 stores the data bytes that follow the address, MSB first, starting at that address. A new byte replaces the old contents.
- R4: Instruction 0x03 returns stored bytes MSB first. SO changes after falling SCK edges, starting with the falling edge that ends the last address bit, and `so_oe` is high while bits are sent.
- R5: Instruction 0x01 loads the mode byte from the next data byte, and 0x05 returns it as `{mode[1:0], 6'b0}`. The mode bits [7:6] mean: 00 single byte, 10 page, 01 stream. The value 11 acts as single byte.
- R6: In single-byte mode only one data byte moves per transaction. Later clocks neither write nor drive SO until `cs_n` rises.
- R7: In page mode the pointer steps within an aligned block of 2**`PAGE_W` bytes. After the last byte of the page it returns to the first byte of the same page.
- R8: In stream mode the pointer steps through the whole array. After address 2**`ADDR_W`-1 it wraps to 0.
- R9: `so_oe` stays low whenever `cs_n` is high, throughout a write transaction, and after an unknown instruction.
- R10: While `hold_n` is low, SCK edges and SI are ignored, the transaction state is kept, and `so_oe` is low. After `hold_n` rises, the transfer resumes where it stopped.
- R11: Raising `cs_n` part way through a byte aborts the transaction. The partial byte is not stored, and the next transaction decodes from a fresh bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the slave |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out of the slave |
| so_oe | output | 1 | High while `so` should be driven |

## Verification
The bench builds the block with `ADDR_W = 8` and `PAGE_W = 5`. This gives a 256-byte array of eight pages, so the top-of-array wrap in stream mode and the ignored upper address bits can be reached with a few short transfers. Page 1 (0x20 to 0x3F) is used for the in-page return. With an SCK phase of six system clocks, the read path from a rising edge to the next loaded byte is covered with margin.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_STREAM = 2'b01,
    MODE_PAGE   = 2'b10,
    MODE_RSVD   = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WDATA = 3'd2,
    ST_RDATA = 3'd3,
    ST_MODEW = 3'd4,
    ST_MODER = 3'd5,
    ST_DRAIN = 3'd6
  } xfer_st_e;

  localparam logic [BYTE_W-1:0] OPC_MODE_WR = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_MEM_WR  = 8'h02;
  localparam logic [BYTE_W-1:0] OPC_MEM_RD  = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_MODE_RD = 8'h05;

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
  parameter int          N       = 4,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_sram_ptr.sv
module spi_sram_ptr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  input  logic              page_mode,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] nxt_lin;
  logic [ADDR_W-1:0] nxt_page;

  assign nxt_lin = ptr_q + 1'b1;

  generate
    if (PAGE_W < ADDR_W) begin : g_split
      logic [PAGE_W-1:0] low_inc;
      assign low_inc  = ptr_q[PAGE_W-1:0] + 1'b1;
      assign nxt_page = {ptr_q[ADDR_W-1:PAGE_W], low_inc};
    end else begin : g_whole
      assign nxt_page = nxt_lin;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (load) ptr_q <= load_val;
    else if (inc)  ptr_q <= page_mode ? nxt_page : nxt_lin;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/spi_sram_mem.sv
module spi_sram_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);

  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wd;
    rd_q <= cells[addr];
  end

  assign rd = rd_q;

endmodule

// File: rtl/spi_sram.sv
module spi_sram
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int ADDR_FLD_W  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);

  localparam int CNT_W = $clog2(ADDR_FLD_W);
  localparam logic [CNT_W-1:0] LAST_BYTE_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(ADDR_FLD_W - 1);

  // pin synchronizers: {cs_n, hold_n, sck, si}
  logic [3:0] pins_s;
  spi_sram_sync #(
    .N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)
  ) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, hold_n, sck, si}), .q(pins_s)
  );

  logic cs_act, hold_act, sck_s, si_s, sck_prev;
  assign cs_act   = ~pins_s[3];
  assign hold_act = ~pins_s[2];
  assign sck_s    = pins_s[1];
  assign si_s     = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_s;
  end

  logic step_r, step_f;
  assign step_r = cs_act & ~hold_act & sck_s & ~sck_prev;
  assign step_f = cs_act & ~hold_act & ~sck_s & sck_prev;

  // transaction state
  xfer_st_e              state_q;
  xfer_mode_e            mode_q;
  logic [CNT_W-1:0]      bit_cnt;
  logic [ADDR_FLD_W-1:0] rx_sh;
  logic [ADDR_FLD_W-1:0] rx_nxt;
  logic                  rd_q;
  logic                  byte_end, addr_end, single_mode, page_mode;

  assign rx_nxt      = {rx_sh[ADDR_FLD_W-2:0], si_s};
  assign byte_end    = (bit_cnt == LAST_BYTE_BIT);
  assign addr_end    = (bit_cnt == LAST_ADDR_BIT);
  assign page_mode   = (mode_q == MODE_PAGE);
  assign single_mode = (mode_q != MODE_PAGE) && (mode_q != MODE_STREAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CMD;
      mode_q  <= MODE_SINGLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      rd_q    <= 1'b0;
    end else if (!cs_act) begin
      state_q <= ST_CMD;
      bit_cnt <= '0;
    end else if (step_r) begin
      rx_sh <= rx_nxt;
      case (state_q)
        ST_CMD: begin
          if (byte_end) begin
            bit_cnt <= '0;
            case (rx_nxt[BYTE_W-1:0])
              OPC_MEM_WR:  begin state_q <= ST_ADDR; rd_q <= 1'b0; end
              OPC_MEM_RD:  begin state_q <= ST_ADDR; rd_q <= 1'b1; end
              OPC_MODE_WR: state_q <= ST_MODEW;
              OPC_MODE_RD: state_q <= ST_MODER;
              default:     state_q <= ST_DRAIN;
            endcase
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_ADDR: begin
          if (addr_end) begin
            bit_cnt <= '0;
            state_q <= rd_q ? ST_RDATA : ST_WDATA;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_WDATA, ST_RDATA: begin
          if (byte_end) begin
            bit_cnt <= '0;
            if (single_mode) state_q <= ST_DRAIN;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_MODEW: begin
          if (byte_end) begin
            mode_q  <= xfer_mode_e'(rx_nxt[BYTE_W-1:BYTE_W-2]);
            state_q <= ST_DRAIN;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_MODER: begin
          if (byte_end) state_q <= ST_DRAIN;
          else          bit_cnt <= bit_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // pointer and array
  logic              ptr_load, ptr_inc, mem_we;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] mem_rd;

  assign ptr_load = step_r && (state_q == ST_ADDR) && addr_end;
  assign ptr_inc  = step_r && byte_end &&
                    ((state_q == ST_WDATA) || (state_q == ST_RDATA));
  assign mem_we   = step_r && byte_end && (state_q == ST_WDATA);

  spi_sram_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst(rst),
    .load(ptr_load), .load_val(rx_nxt[ADDR_W-1:0]),
    .inc(ptr_inc), .page_mode(page_mode),
    .ptr(ptr)
  );

  spi_sram_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(ptr),
    .wd(rx_nxt[BYTE_W-1:0]), .rd(mem_rd)
  );

  // serial output path
  logic              tx_state, tx_live, so_q, so_oe_q;
  logic [BYTE_W-1:0] tx_sh, tx_src;

  assign tx_state = (state_q == ST_RDATA) || (state_q == ST_MODER);
  assign tx_src   = (state_q == ST_MODER) ? {mode_q, {(BYTE_W-2){1'b0}}} : mem_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_live <= 1'b0;
      tx_sh   <= '0;
      so_q    <= 1'b0;
      so_oe_q <= 1'b0;
    end else begin
      if (!cs_act || !tx_state) begin
        tx_live <= 1'b0;
      end else if (step_f) begin
        tx_live <= 1'b1;
        if (bit_cnt == '0) begin
          so_q  <= tx_src[BYTE_W-1];
          tx_sh <= {tx_src[BYTE_W-2:0], 1'b0};
        end else begin
          so_q  <= tx_sh[BYTE_W-1];
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
      so_oe_q <= cs_act && !hold_act && tx_live;
    end
  end

  assign so    = so_q;
  assign so_oe = so_oe_q;

endmodule

// File: rtl/spi_sram_chk.sv
module spi_sram_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              hold_act,
  input logic              so_oe,
  input logic [2:0]        state,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [ADDR_W-1:0] ptr,
  input logic              ptr_inc,
  input logic              mem_we,
  input logic [1:0]        mode
);

  localparam logic [2:0] S_WDATA = 3'd2;
  localparam logic [2:0] S_DRAIN = 3'd6;

  a_r9_oe_off_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !so_oe);

  a_r9_write_no_drive: assert property (@(posedge clk) disable iff (rst)
    (state == S_WDATA) |-> !so_oe);

  a_r10_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    (cs_act && hold_act) |=> ($stable(state) && $stable(bit_cnt) && $stable(ptr)));

  a_r10_hold_oe_off: assert property (@(posedge clk) disable iff (rst)
    hold_act |=> !so_oe);

  a_r10_hold_no_write: assert property (@(posedge clk) disable iff (rst)
    hold_act |-> !mem_we);

  a_r7_page_stays: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && mode == 2'b10) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  a_r8_stream_step: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && mode == 2'b01) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  a_r6_single_drains: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && mode[1] == mode[0]) |=> (state == S_DRAIN || !cs_act));

endmodule

bind spi_sram spi_sram_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .hold_act(hold_act),
  .so_oe(so_oe), .state(state_q), .bit_cnt(bit_cnt), .ptr(ptr),
  .ptr_inc(ptr_inc), .mem_we(mem_we), .mode(mode_q)
);

// File: tb/test_spi_sram.sv
`timescale 1ns/1ps
module test_spi_sram;

  localparam int AW = 8;
  localparam int PW = 5;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;

  always #2.5 clk = ~clk;

  spi_sram #(.ADDR_W(AW), .PAGE_W(PW)) i_spi_sram (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe)
  );

  int n_run = 0;
  int n_fail = 0;

  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic       rall [8];
  logic       rany [8];
  logic       w_oe_any;

  // {write addr, write data, read addr, expected}
  localparam logic [47:0] VEC [6] = '{
    {16'h0012, 8'hA5, 16'h0012, 8'hA5},
    {16'h0012, 8'h5A, 16'h0012, 8'h5A},
    {16'hE034, 8'h3C, 16'h0034, 8'h3C},
    {16'h00FF, 8'h81, 16'h00FF, 8'h81},
    {16'h0000, 8'h7E, 16'h0000, 8'h7E},
    {16'h1F80, 8'hC3, 16'h0080, 8'hC3}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r, output logic oe);
    @(negedge clk) si = b;
    repeat (H-1) @(negedge clk);
    r = so; oe = so_oe;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx, output logic all, output logic any);
    logic r, oe;
    all = 1'b1; any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sbit(tx[i], r, oe);
      rx[i] = r; all &= oe; any |= oe;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [15:0] a, output logic any);
    logic [7:0] d; logic al, an;
    sbyte(op, d, al, an); any = an;
    sbyte(a[15:8], d, al, an); any |= an;
    sbyte(a[7:0], d, al, an); any |= an;
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    logic [7:0] d; logic al, an;
    cs_lo();
    send_hdr(8'h02, a, w_oe_any);
    for (int i = 0; i < n; i++) begin
      sbyte(wbuf[i], d, al, an); w_oe_any |= an;
    end
    cs_hi();
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic an;
    cs_lo();
    send_hdr(8'h03, a, an);
    for (int i = 0; i < n; i++) sbyte(8'h00, rbuf[i], rall[i], rany[i]);
    cs_hi();
  endtask

  task automatic set_mode(input logic [7:0] m);
    logic [7:0] d; logic al, an;
    cs_lo(); sbyte(8'h01, d, al, an); sbyte(m, d, al, an); cs_hi();
  endtask

  task automatic get_mode(output logic [7:0] m);
    logic [7:0] d; logic al, an;
    cs_lo(); sbyte(8'h05, d, al, an); sbyte(8'h00, m, al, an); cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] m, d;
    logic r, oe, al, an;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(so_oe == 1'b0, "R1 so_oe after reset", so_oe, 0);
    get_mode(m);
    chk(m == 8'h00, "R1 R5 mode after reset", m, 8'h00);

    // table walk in single-byte mode (R2 R3 R4 R9)
    for (int k = 0; k < 6; k++) begin
      wbuf[0] = VEC[k][31:24];
      do_write(VEC[k][47:32], 1);
      chk(w_oe_any == 1'b0, "R9 so_oe during write", w_oe_any, 0);
      do_read(VEC[k][23:8], 1);
      chk(rbuf[0] == VEC[k][7:0], "R2 R3 R4 read after write", rbuf[0], VEC[k][7:0]);
      chk(rall[0] == 1'b1, "R4 so_oe while reading", rall[0], 1);
    end

    // R6 single-byte mode: second byte neither stored nor sent
    wbuf[0] = 8'h5A; do_write(16'h0011, 1);
    wbuf[0] = 8'h33; wbuf[1] = 8'h77; do_write(16'h0010, 2);
    do_read(16'h0011, 1);
    chk(rbuf[0] == 8'h5A, "R6 extra write byte ignored", rbuf[0], 8'h5A);
    do_read(16'h0010, 2);
    chk(rbuf[0] == 8'h33, "R6 first byte read", rbuf[0], 8'h33);
    chk(rany[1] == 1'b0, "R6 no drive after one byte", rany[1], 0);

    // R5 R7 page mode
    set_mode(8'h80);
    get_mode(m);
    chk(m == 8'h80, "R5 page mode readback", m, 8'h80);
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC; wbuf[3] = 8'hDD;
    do_write(16'h003E, 4);
    do_read(16'h003F, 3);
    chk(rbuf[0] == 8'hBB, "R7 last byte of page", rbuf[0], 8'hBB);
    chk(rbuf[1] == 8'hCC, "R7 wrap to page start", rbuf[1], 8'hCC);
    chk(rbuf[2] == 8'hDD, "R7 page start plus one", rbuf[2], 8'hDD);

    // R5 R8 stream mode
    set_mode(8'h40);
    get_mode(m);
    chk(m == 8'h40, "R5 stream mode readback", m, 8'h40);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(16'h00FE, 3);
    do_read(16'h00FF, 2);
    chk(rbuf[0] == 8'h22, "R8 top of array", rbuf[0], 8'h22);
    chk(rbuf[1] == 8'h33, "R8 wrap to zero", rbuf[1], 8'h33);
    chk(rall[1] == 1'b1, "R8 drive continues", rall[1], 1);

    // R9 unknown instruction
    cs_lo();
    sbyte(8'h07, d, al, an);
    w_oe_any = an;
    for (int i = 0; i < 3; i++) begin sbyte(8'hFF, d, al, an); w_oe_any |= an; end
    cs_hi();
    chk(w_oe_any == 1'b0, "R9 unknown opcode no drive", w_oe_any, 0);
    do_read(16'h00FE, 1);
    chk(rbuf[0] == 8'h11, "R9 unknown opcode no store", rbuf[0], 8'h11);

    // R10 hold during write
    cs_lo();
    send_hdr(8'h02, 16'h0050, an);
    for (int i = 7; i >= 4; i--) sbit(8'h96 >> i, r, oe);
    @(negedge clk) hold_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) sbit(1'b1, r, oe);
    @(negedge clk) hold_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 3; i >= 0; i--) sbit(8'h96 >> i, r, oe);
    cs_hi();
    do_read(16'h0050, 1);
    chk(rbuf[0] == 8'h96, "R10 write resumes after hold", rbuf[0], 8'h96);

    // R10 hold during read
    cs_lo();
    send_hdr(8'h03, 16'h0050, an);
    @(negedge clk) hold_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(so_oe == 1'b0, "R10 so_oe low in hold", so_oe, 0);
    hold_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(so_oe == 1'b1, "R10 so_oe back after hold", so_oe, 1);
    sbyte(8'h00, d, al, an);
    cs_hi();
    chk(d == 8'h96, "R10 read resumes after hold", d, 8'h96);

    // R11 abort mid-byte
    wbuf[0] = 8'h44; do_write(16'h0060, 1);
    cs_lo();
    send_hdr(8'h02, 16'h0060, an);
    for (int i = 0; i < 5; i++) sbit(1'b1, r, oe);
    cs_hi();
    do_read(16'h0060, 1);
    chk(rbuf[0] == 8'h44, "R11 partial byte not stored", rbuf[0], 8'h44);
    cs_lo();
    for (int i = 0; i < 3; i++) sbit(1'b0, r, oe);
    cs_hi();
    do_read(16'h00FF, 1);
    chk(rbuf[0] == 8'h22, "R11 decode restarts cleanly", rbuf[0], 8'h22);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule